// File: doc/BRIEF.md
# Calibrated Seconds Prescaler for a Real-Time Clock

This block turns a crystal-rate clock enable into a one-cycle pulse per second. It also raises a minute marker at every minute boundary. Crystal frequency error is cancelled once per minute. A signed 8-bit trim value, scaled by four, shortens or lengthens the first second of each minute by that many crystal ticks. Every other second keeps the nominal length of `NOMINAL_DIV` ticks (32,768 by default).

Downstream calendar logic consumes `sec_pulse` and `min_mark`. The trim is written through `cal_wr`/`cal_din`. A write is only taken while the timer is stopped (`run` low) or in the single cycle in which `sec_pulse` is high. This keeps a new trim from landing part-way through a second.

Top module: `rtc_cal_prescaler`

## Requirements
- R1: After reset, `sec_pulse` and `min_mark` are low, the stored trim is 0 and the second index is 0, so the fourth (in general the `SEC_PER_MIN`-th) seconds pulse after starting is the first one carrying `min_mark`.
- R2: `sec_pulse` is high for exactly one clock cycle at the end of each second. A second other than the first of a minute lasts `NOMINAL_DIV` counted ticks.
- R3: The first second of each minute lasts `NOMINAL_DIV - CAL_STEP*cal` counted ticks, with `cal` read as 8-bit two's complement and `CAL_STEP` = 4. A positive value shortens the second (slow crystal) and a negative value lengthens it (fast crystal). With `cal` = 0 a minute is exactly `SEC_PER_MIN*NOMINAL_DIV` ticks.
- R4: `min_mark` is high only together with the `sec_pulse` that ends the last second of a minute (index `SEC_PER_MIN-1`), so it marks the start of the corrected second.
- R5: A write (`cal_wr` high) is stored when `run` is low or `sec_pulse` is high in the same cycle. The new value governs seconds from the next cycle on.
- R6: A write made while `run` is high and `sec_pulse` is low is ignored and leaves the stored trim unchanged.
- R7: While `run` is low, no ticks are counted, the divider and second index hold, and `sec_pulse` stays low.
- R8: Only cycles with `tick_en` high advance the divider. With `tick_en` high every other cycle, each second takes twice as many clock cycles.
- R9: The extreme trims work: -128 adds 512 ticks and +127 removes 508 ticks per minute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| run | input | 1 | Timer enable; low stops counting and opens the write window |
| tick_en | input | 1 | Crystal-rate tick qualifier |
| cal_wr | input | 1 | Trim write strobe |
| cal_din | input | 8 | Signed trim value, two's complement |
| sec_pulse | output | 1 | One-cycle seconds pulse |
| min_mark | output | 1 | One-cycle minute marker, coincident with `sec_pulse` |

## Verification
The tick that completes a second is registered, so `sec_pulse` and `min_mark` rise one cycle after the terminal tick edge. The bench therefore measures whole intervals between successive pulse rises, sampled on the falling edge, rather than absolute times. A trim write is captured on the edge that follows its strobe. Its effect is checked only in a later corrected first second, found by synchronising to a `min_mark` pulse. For the stop test, `run` is held low for an exact number of rising edges, and the pulse interval is expected to grow by exactly that number.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int CAL_W = 8;
  typedef logic signed [CAL_W-1:0] cal_t;
endpackage

// File: rtl/rtc_cal_store.sv
module rtc_cal_store
  import rtc_cal_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic sec_pulse,
  input  logic cal_wr,
  input  cal_t cal_din,
  output cal_t cal_q
);
  logic take;
  cal_t cal_d;

  always_comb begin
    take  = cal_wr && (!run || sec_pulse);
    cal_d = take ? cal_din : cal_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cal_q <= '0;
    else        cal_q <= cal_d;
  end

  // R6: outside the window a write cannot alter the trim
  a_r6_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !sec_pulse) |=> $stable(cal_q));
endmodule

// File: rtl/rtc_sec_div.sv
module rtc_sec_div
  import rtc_cal_pkg::*;
#(
  parameter int NOMINAL_DIV = 32768,
  parameter int CAL_STEP    = 4,
  localparam int MAX_TERM   = NOMINAL_DIV + CAL_STEP * (2 ** (CAL_W - 1)),
  localparam int DIV_W      = $clog2(MAX_TERM + 1)
)(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick_en,
  input  logic first_sec,
  input  cal_t cal,
  output logic sec_hit
);
  logic [DIV_W-1:0] cnt_q, cnt_d, last_val;
  logic             adv;
  int               term_i;

  always_comb begin
    term_i   = NOMINAL_DIV - (first_sec ? CAL_STEP * int'(cal) : 0);
    last_val = DIV_W'(term_i - 1);
    adv      = run && tick_en;
    sec_hit  = adv && (cnt_q >= last_val);
    cnt_d    = cnt_q;
    if (adv) cnt_d = sec_hit ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3: the divider never runs beyond the longest legal second
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < DIV_W'(MAX_TERM));
  // R8: a cycle without a tick leaves the divider alone
  a_r8_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(cnt_q));
endmodule

// File: rtl/rtc_min_cnt.sv
module rtc_min_cnt #(
  parameter int SEC_PER_MIN = 60,
  localparam int SEC_W      = $clog2(SEC_PER_MIN)
)(
  input  logic clk,
  input  logic rst_n,
  input  logic sec_hit,
  output logic first_sec,
  output logic last_sec
);
  logic [SEC_W-1:0] sec_q, sec_d;

  always_comb begin
    first_sec = (sec_q == '0);
    last_sec  = (sec_q == SEC_W'(SEC_PER_MIN - 1));
    sec_d     = sec_q;
    if (sec_hit) sec_d = last_sec ? '0 : sec_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sec_q <= '0;
    else        sec_q <= sec_d;
  end

  // R4: second index stays inside one minute
  a_r4_index_range: assert property (@(posedge clk) disable iff (!rst_n)
    sec_q <= SEC_W'(SEC_PER_MIN - 1));
endmodule

// File: rtl/rtc_cal_prescaler.sv
module rtc_cal_prescaler
  import rtc_cal_pkg::*;
#(
  parameter int NOMINAL_DIV = 32768,
  parameter int SEC_PER_MIN = 60,
  parameter int CAL_STEP    = 4
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       tick_en,
  input  logic       cal_wr,
  input  logic [7:0] cal_din,
  output logic       sec_pulse,
  output logic       min_mark
);
  cal_t cal_q;
  logic first_sec, last_sec, sec_hit;
  logic sec_pulse_d, min_mark_d;

  rtc_cal_store u_store (
    .clk(clk), .rst_n(rst_n), .run(run), .sec_pulse(sec_pulse),
    .cal_wr(cal_wr), .cal_din(cal_t'(cal_din)), .cal_q(cal_q)
  );

  rtc_sec_div #(.NOMINAL_DIV(NOMINAL_DIV), .CAL_STEP(CAL_STEP)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .tick_en(tick_en),
    .first_sec(first_sec), .cal(cal_q), .sec_hit(sec_hit)
  );

  rtc_min_cnt #(.SEC_PER_MIN(SEC_PER_MIN)) u_min (
    .clk(clk), .rst_n(rst_n), .sec_hit(sec_hit),
    .first_sec(first_sec), .last_sec(last_sec)
  );

  always_comb begin
    sec_pulse_d = sec_hit;
    min_mark_d  = sec_hit && last_sec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_pulse <= 1'b0;
      min_mark  <= 1'b0;
    end else begin
      sec_pulse <= sec_pulse_d;
      min_mark  <= min_mark_d;
    end
  end

  // R4: minute marker only rides on a seconds pulse
  a_r4_min_with_sec: assert property (@(posedge clk) disable iff (!rst_n)
    min_mark |-> sec_pulse);
  // R2: seconds pulse lasts one cycle
  a_r2_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |=> !sec_pulse);
  // R7: a stopped timer produces no pulse
  a_r7_stopped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !sec_pulse);
endmodule

// File: tb/rtc_cal_prescaler_test.sv
module rtc_cal_prescaler_test;
  localparam int CLK_PERIOD = 10;
  localparam int NOM  = 1024;
  localparam int SPM  = 4;
  localparam int STEP = 4;

  logic clk = 1'b0;
  logic rst_n, run, tick_en, cal_wr;
  logic [7:0] cal_din;
  logic sec_pulse, min_mark;
  int cyc = 0;
  int checks = 0;
  int errs = 0;
  bit tick_half = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) tick_en <= tick_half ? ~tick_en : 1'b1;

  rtc_cal_prescaler #(.NOMINAL_DIV(NOM), .SEC_PER_MIN(SPM), .CAL_STEP(STEP)) uut (
    .clk(clk), .rst_n(rst_n), .run(run), .tick_en(tick_en),
    .cal_wr(cal_wr), .cal_din(cal_din), .sec_pulse(sec_pulse), .min_mark(min_mark)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_pulse(output int at, output bit mm);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!sec_pulse && n < 20000);
    if (!sec_pulse) check("timeout", 0, 1);
    at = cyc;
    mm = min_mark;
  endtask

  task automatic sync_min(output int at);
    bit mm = 1'b0;
    int guard = 0;
    while (!mm && guard < 2 * SPM + 2) begin
      wait_pulse(at, mm);
      guard++;
    end
  endtask

  // measures one minute after a marker; first second uses trim c
  task automatic measure_minute(input string req, input int c, input int mul);
    int t0, t1;
    bit mm;
    sync_min(t0);
    for (int s = 0; s < SPM; s++) begin
      wait_pulse(t1, mm);
      check(req, t1 - t0, mul * ((s == 0) ? NOM - STEP * c : NOM));
      check(req, int'(mm), (s == SPM - 1) ? 1 : 0);
      t0 = t1;
    end
  endtask

  task automatic write_stopped(input int v);
    @(negedge clk); run = 1'b0; cal_wr = 1'b1; cal_din = 8'(v);
    @(negedge clk); cal_wr = 1'b0; run = 1'b1;
  endtask

  task automatic t_reset;
    check("R1 sec_pulse", int'(sec_pulse), 0);
    check("R1 min_mark", int'(min_mark), 0);
  endtask

  task automatic t_first_minute;
    int t0, t1; bit mm;
    t0 = cyc;
    for (int s = 0; s < SPM; s++) begin
      wait_pulse(t1, mm);
      check("R1 R2 interval", t1 - t0, NOM);
      check("R1 R4 marker", int'(mm), (s == SPM - 1) ? 1 : 0);
      t0 = t1;
    end
  endtask

  task automatic t_extremes;
    write_stopped(127);
    measure_minute("R9 R3 +127", 127, 1);
    write_stopped(-128);
    measure_minute("R9 R3 -128", -128, 1);
  endtask

  task automatic t_blocked_write;
    int t; bit mm;
    wait_pulse(t, mm);
    repeat (5) @(negedge clk);
    cal_wr = 1'b1; cal_din = 8'd20;
    @(negedge clk); cal_wr = 1'b0;
    measure_minute("R6 ignored", -128, 1);
  endtask

  task automatic t_window_write;
    int t; bit mm = 1'b1;
    while (mm) wait_pulse(t, mm);
    cal_wr = 1'b1; cal_din = 8'd10;
    @(negedge clk); cal_wr = 1'b0;
    measure_minute("R5 window", 10, 1);
  endtask

  task automatic t_stop_hold;
    int t0, t1, seen = 0; bit mm = 1'b1;
    while (mm) wait_pulse(t0, mm);
    repeat (100) @(negedge clk);
    run = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (sec_pulse) seen++;
    end
    run = 1'b1;
    check("R7 no pulse", seen, 0);
    wait_pulse(t1, mm);
    check("R7 hold", t1 - t0, NOM + 300);
  endtask

  task automatic t_half_tick;
    tick_half = 1'b1;
    measure_minute("R8 half rate", 10, 2);
    tick_half = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check("watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; run = 1'b0; cal_wr = 1'b0; cal_din = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run = 1'b1;
    t_first_minute();
    measure_minute("R3 zero trim", 0, 1);
    t_extremes();
    t_blocked_write();
    t_window_write();
    t_stop_hold();
    t_half_tick();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule